// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a programmable down-counter that drives a single active-low pulse. Software programs a 16-bit pulse length through an 8-bit write port, low byte first and high byte second. Each rising edge seen on the gate input starts a pulse. The output drops on the next counting-clock enable and stays low for exactly the programmed number of counting enables. A further gate edge during a pulse restarts it at full length, so the output stays low for the full count after the most recent edge. The live count is always visible on a read port. Reading it has no side effects.

The programmed length sits in its own holding register, which is separate from the running counter. A byte write never disturbs a pulse that is already in progress. The new length applies from the next trigger. A programmed value of zero stands for 65536 counts. The whole block runs on one clock. The counting clock and the gate are sampled as synchronous enables, and the asynchronous reset is released in step with the clock.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the output `pulse_n` is 1 (high) and `count_out` is 0.
- R2: The length is loaded by two writes on `wr_en`. The first write supplies bits 7:0 and the second supplies bits 15:8. Only the second write completes the load, and a lone first write arms nothing.
- R3: Until a complete two-byte load has happened, gate edges are ignored and `pulse_n` stays 1.
- R4: A gate rising edge (gate 0 in one cycle, 1 in the next) is held pending until the first cycle with `cnt_en` = 1, counting the edge cycle itself. On the clock edge of that cycle `pulse_n` becomes 0 and `count_out` takes the programmed length.
- R5: During a pulse, each cycle with `cnt_en` = 1 lowers `count_out` by one. On the enable that takes it from 1 to 0, `pulse_n` returns to 1, so the pulse lasts exactly N counting enables. Cycles without `cnt_en` change nothing.
- R6: A programmed length of 0 produces a pulse of 65536 counting enables. `count_out` reads 0 at the start of that pulse and 65535 after its first enable.
- R7: A gate rising edge during a pulse reloads the full programmed length at the next counting enable, with `pulse_n` held at 0.
- R8: A length written during a pulse does not change that pulse. The next trigger loads the new length. A load that completes in the same cycle as a trigger is not used by that trigger.
- R9: Holding the gate at 1 does not cause any further trigger. Only 0-to-1 transitions start or restart a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Counting-clock enable; one count per cycle where it is 1 |
| gate_in | input | 1 | Gate level; its rising edges trigger pulses |
| wr_en | input | 1 | Byte write strobe for the length register |
| wr_data | input | 8 | Length byte, low byte first then high byte |
| count_out | output | 16 | Live value of the running counter |
| pulse_n | output | 1 | Active-low one-shot output |

## Verification
Every result is registered once. A gate edge or a counting enable presented in a cycle shows up on `pulse_n` and `count_out` just after the next rising clock edge. A completed byte load changes only the holding register, so it is visible only through the following trigger. The bench drives inputs shortly after a rising edge, steps one edge, and compares the outputs a short delay after that edge. The expected values come from a per-cycle model of the requirements, and pulse lengths are measured directly in counting enables.

// File: rtl/os_pkg.sv
package os_pkg;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_PULSE = 1'b1
  } os_phase_e;

endpackage

// File: rtl/os_rst_sync.sv
module os_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/os_loader.sv
module os_loader #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_q,
  output logic              loaded_q
);

  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0] count_d;
  logic             loaded_d;
  logic             last_byte;

  assign last_byte = (ptr_q == PTR_W'(NBYTES - 1));

  // byte lane capture: the lane selected by the pointer takes the write data
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_comb begin
      if (wr_en && (ptr_q == PTR_W'(b))) begin
        stage_d[b*BYTE_W +: BYTE_W] = wr_data;
      end else begin
        stage_d[b*BYTE_W +: BYTE_W] = stage_q[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    ptr_d    = ptr_q;
    count_d  = count_q;
    loaded_d = loaded_q;
    if (wr_en) begin
      if (last_byte) begin
        ptr_d    = '0;
        count_d  = stage_d;
        loaded_d = 1'b1;
      end else begin
        ptr_d = ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      stage_q  <= '0;
      count_q  <= '0;
      loaded_q <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      stage_q  <= stage_d;
      count_q  <= count_d;
      loaded_q <= loaded_d;
    end
  end

  AST_PARTIAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !last_byte) |=> ($stable(count_q) && $stable(loaded_q))); // R2

  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && last_byte) |=> loaded_q); // R2

endmodule

// File: rtl/os_trigger.sv
module os_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic gate_in,
  output logic fire
);

  logic gate_q;
  logic pend_q, pend_d;
  logic rise;
  logic want;

  assign rise = gate_in & ~gate_q;
  assign want = pend_q | rise;
  assign fire = cnt_en & want;

  always_comb begin
    if (cnt_en) begin
      pend_d = 1'b0;
    end else begin
      pend_d = want;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate_in;
      pend_q <= pend_d;
    end
  end

  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !cnt_en) |=> (cnt_en |-> fire)); // R4

endmodule

// File: rtl/os_downcount.sv
module os_downcount
  import os_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fire,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W:0]   cnt_q,
  output logic             pulse_n
);

  localparam logic [CNT_W:0] FULL_RANGE = {1'b1, {CNT_W{1'b0}}};

  os_phase_e        phase_q, phase_d;
  logic [CNT_W:0]   cnt_d;
  logic [CNT_W:0]   load_val;

  assign load_val = (reload == '0) ? FULL_RANGE : {1'b0, reload};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (fire) begin
      phase_d = PH_PULSE;
      cnt_d   = load_val;
    end else if (tick && (phase_q == PH_PULSE)) begin
      cnt_d = cnt_q - (CNT_W+1)'(1);
      if (cnt_q == (CNT_W+1)'(1)) begin
        phase_d = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_n = (phase_q == PH_IDLE);

  AST_LOW_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pulse_n); // R4

  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == ((reload == '0) ? FULL_RANGE : {1'b0, $past(reload)}))); // R7

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fire && !pulse_n) |=> (cnt_q == $past(cnt_q) - (CNT_W+1)'(1))); // R5

  AST_RELEASE_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fire && !pulse_n && cnt_q == (CNT_W+1)'(1)) |=> pulse_n); // R5

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !fire) |=> ($stable(cnt_q) && $stable(pulse_n))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_RANGE); // R6

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              gate_in,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_out,
  output logic              pulse_n
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] hold_len;
  logic             armed;
  logic             fire_raw;
  logic             fire_armed;
  logic [CNT_W:0]   run_cnt;

  os_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  os_loader #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_load (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .count_q  (hold_len),
    .loaded_q (armed)
  );

  os_trigger u_trig (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cnt_en  (cnt_en),
    .gate_in (gate_in),
    .fire    (fire_raw)
  );

  assign fire_armed = fire_raw & armed;

  os_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (cnt_en),
    .fire    (fire_armed),
    .reload  (hold_len),
    .cnt_q   (run_cnt),
    .pulse_n (pulse_n)
  );

  assign count_out = run_cnt[CNT_W-1:0];

  AST_UNARMED_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !armed |-> pulse_n); // R3

  AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !cnt_en) |=> ($stable(pulse_n) && $stable(count_out))); // R8

endmodule

// File: tb/oneshot_timer_tb_top.sv
module oneshot_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cnt_en;
  logic        gate_in;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [15:0] count_out;
  logic        pulse_n;

  int n_chk;
  int n_bad;
  string cur_tag;

  oneshot_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .gate_in   (gate_in),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .count_out (count_out),
    .pulse_n   (pulse_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural model of the requirements, one update per clock
  logic [15:0] m_len;
  logic [7:0]  m_lo;
  logic        m_ptr;
  logic        m_armed;
  logic        m_gprev;
  logic        m_pend;
  logic [16:0] m_cnt;
  logic        m_low;

  function automatic logic [16:0] full_len(input logic [15:0] len);
    return (len == 16'd0) ? 17'h10000 : {1'b0, len};
  endfunction

  always @(posedge clk) begin
    logic want;
    if (!rst_n) begin
      m_len = 0; m_lo = 0; m_ptr = 0; m_armed = 0;
      m_gprev = 0; m_pend = 0; m_cnt = 0; m_low = 0;
    end else begin
      want = m_pend | (gate_in & ~m_gprev);
      if (cnt_en && want && m_armed) begin
        m_cnt = full_len(m_len);
        m_low = 1;
      end else if (cnt_en && m_low) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_low = 0;
      end
      m_pend = cnt_en ? 1'b0 : want;
      if (wr_en) begin
        if (!m_ptr) begin
          m_lo = wr_data; m_ptr = 1;
        end else begin
          m_len = {wr_data, m_lo}; m_ptr = 0; m_armed = 1;
        end
      end
      m_gprev = gate_in;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic g, input logic we, input logic [7:0] wd);
    cnt_en = en; gate_in = g; wr_en = we; wr_data = wd;
    @(posedge clk);
    #2;
    check(cur_tag, int'(pulse_n), int'(!m_low));
    check(cur_tag, int'(count_out), int'(m_cnt[15:0]));
  endtask

  task automatic write_len(input logic [15:0] len);
    step(0, 0, 1, len[7:0]);
    step(0, 0, 1, len[15:8]);
  endtask

  task automatic trig();
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
  endtask

  task automatic run_out(input logic g, output int n);
    n = 0;
    while (pulse_n == 1'b0 && n < 70000) begin
      step(1, g, 0, 0);
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len;
    void'($urandom(32'h5EED1234));
    n_chk = 0; n_bad = 0;
    cnt_en = 0; gate_in = 0; wr_en = 0; wr_data = 0;
    rst_n = 0;
    cur_tag = "R1";
    repeat (5) @(posedge clk);
    #2;
    check("R1", int'(pulse_n), 1);
    check("R1", int'(count_out), 0);
    rst_n = 1;
    repeat (4) step(0, 0, 0, 0);
    check("R1", int'(pulse_n), 1);
    check("R1", int'(count_out), 0);

    // R3: trigger with nothing programmed
    cur_tag = "R3";
    trig();
    step(1, 0, 0, 0);
    check("R3", int'(pulse_n), 1);

    // R2: only the low byte written
    cur_tag = "R2";
    step(0, 0, 1, 8'd5);
    trig();
    step(1, 0, 0, 0);
    check("R2", int'(pulse_n), 1);
    step(0, 0, 1, 8'd0);   // completes length 5

    // R4: edge while counting enable is off stays pending
    cur_tag = "R4";
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    check("R4", int'(pulse_n), 1);
    step(1, 1, 0, 0);
    check("R4", int'(pulse_n), 0);
    check("R4", int'(count_out), 5);

    // R5 and R9: gate kept high, pulse lasts exactly five enables
    cur_tag = "R5";
    step(0, 1, 0, 0);
    check("R5", int'(count_out), 5);
    run_out(1'b1, len);
    check("R9", len, 5);
    check("R5", int'(pulse_n), 1);
    step(1, 1, 0, 0);
    check("R9", int'(pulse_n), 1);

    // R7: retrigger after two counts
    cur_tag = "R7";
    trig();
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    check("R7", int'(count_out), 3);
    step(1, 0, 0, 0);
    check("R7", int'(count_out), 2);
    step(1, 1, 0, 0);
    check("R7", int'(count_out), 5);
    check("R7", int'(pulse_n), 0);
    run_out(1'b1, len);
    check("R7", len, 5);

    // R8: new length written during a pulse
    cur_tag = "R8";
    trig();
    write_len(16'd9);
    run_out(1'b0, len);
    check("R8", len, 5);
    trig();
    check("R8", int'(count_out), 9);
    run_out(1'b0, len);
    check("R8", len, 9);

    // R6: zero means 65536
    cur_tag = "R6";
    write_len(16'd0);
    trig();
    check("R6", int'(count_out), 0);
    check("R6", int'(pulse_n), 0);
    step(1, 1, 0, 0);
    check("R6", int'(count_out), 65535);
    run_out(1'b1, len);
    check("R6", len, 65535);

    // random traffic against the model
    cur_tag = "R5";
    write_len(16'd4);
    for (int i = 0; i < 4000; i++) begin
      logic en, g, we;
      logic [7:0] wd;
      en = ($urandom % 3) != 0;
      g  = ($urandom % 5) == 0 ? ~gate_in : gate_in;
      we = ($urandom % 23) == 0;
      wd = m_ptr ? 8'd0 : 8'(1 + ($urandom % 11));
      step(en, g, we, wd);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule